// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Unit

This block is the address and control front end of a pipelined synchronous burst SRAM. A small word-organised storage array sits behind it so that the whole path can be exercised. On every rising clock edge it samples three chip enables, two active-low address strobes, an active-low step input, per-byte write enables, the address and the write data. From these it decides whether to start a new burst, continue the current one or end it.

There are two strobes. The processor-side strobe only starts reads. It is honoured only while the primary enable is low, and it takes precedence over everything else sampled in that cycle. The controller-side strobe starts either a read or a write, chosen by the byte write enables. When it is sampled with the primary enable high, it deselects the device.

Within a burst, a two-bit beat counter walks the lowest two address bits. The counter runs in either linear or interleaved order, selected by a static strap. Reads return through an address register, an array access stage and an output register. Each data byte carries its own parity bit, which is stored and returned along with the byte.

Top module: `sburst_sram_core`

## Requirements
- R1: When `proc_stb_n`=0 and `chip_en_n`=0 with `chip_en2`=1 and `chip_en3_n`=0, the block loads `addr` as the burst start at beat 0 and reads that word. This holds even when `ctrl_stb_n` is also 0; `byte_wr_n` and `wdata` are ignored and nothing is written.
- R2: While `chip_en_n`=1, `proc_stb_n` has no effect. With `ctrl_stb_n`=1, an active burst continues exactly as if the strobe were high.
- R3: When the processor strobe is honoured (`chip_en_n`=0) but `chip_en2`=0 or `chip_en3_n`=1, the device is deselected. No access happens in that cycle, the burst ends, and later cycles without a strobe make no access.
- R4: When `ctrl_stb_n`=0 with all three enables active, and the processor strobe is not honoured, the block loads `addr` at beat 0. It writes if any bit of `byte_wr_n` is 0, and reads otherwise.
- R5: When `ctrl_stb_n`=0 while `chip_en_n`=1, or while `chip_en2`=0 or `chip_en3_n`=1, the device is deselected with no access, provided the processor strobe is not honoured.
- R6: Beat k of a burst keeps the upper address bits of the start address. With `order_il`=0, its two low bits are (start+k) mod 4. With `order_il`=1, they are start XOR k.
- R7: In a cycle with neither strobe honoured and a burst active, `step_n`=0 advances one beat and accesses the new address, while `step_n`=1 accesses the same address again. The access is a write if any bit of `byte_wr_n` is 0, and a read otherwise.
- R8: A read whose address is registered at clock edge k drives the word on `rdata` with `rvalid`=1 after edge k+2. `rvalid` is 0 in every other cycle, and `rdata` holds its last value while `rvalid`=0.
- R9: Each byte lane i is 9 bits wide and occupies `wdata`/`rdata` bits [9i+8:9i], with bit 9i+8 as that byte's parity. A write stores only the lanes whose `byte_wr_n[i]` is 0. Other lanes keep their content, and all 9 bits of a lane are returned.
- R10: During and right after reset, `rvalid`=0, `rdata`=0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en_n | input | 1 | Primary chip enable, active low |
| chip_en2 | input | 1 | Secondary chip enable, active high |
| chip_en3_n | input | 1 | Secondary chip enable, active low |
| proc_stb_n | input | 1 | Processor-side address strobe (read only), active low |
| ctrl_stb_n | input | 1 | Controller-side address strobe (read or write), active low |
| step_n | input | 1 | Burst step, active low |
| byte_wr_n | input | NBYTES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | NBYTES*9 | Write data, 8 data bits plus parity per lane |
| order_il | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| rdata | output | NBYTES*9 | Registered read data |
| rvalid | output | 1 | Marks a returned beat |

## Verification
The assertions assume that every input is at a known level once reset is released. They also assume that `order_il` changes only while no burst is active; the step and hold properties do not hold across a strap change in the middle of a burst. The random stimulus therefore fixes the strap for each batch and deselects the device before switching it. The bench drives all inputs only at the falling edge, so each value is stable around the sampling edge.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_DESEL = 2'd2,
        CMD_CONT  = 2'd3
    } cmd_e;

    // Low two address bits of beat k from start offset s
    function automatic logic [1:0] beat_offset(input logic [1:0] s,
                                               input logic [1:0] k,
                                               input logic       il);
        return il ? (s ^ k) : (s + k);
    endfunction

endpackage

// File: rtl/sb_strobe_decode.sv
module sb_strobe_decode
    import sburst_pkg::*;
#(
    parameter int NBYTES = 2
) (
    input  logic              chip_en_n,
    input  logic              chip_en2,
    input  logic              chip_en3_n,
    input  logic              proc_stb_n,
    input  logic              ctrl_stb_n,
    input  logic [NBYTES-1:0] byte_wr_n,
    input  logic              burst_active,
    output cmd_e              cmd,
    output logic              is_wr
);

    logic sec_ok;
    logic any_wr;

    always_comb begin
        sec_ok = chip_en2 & ~chip_en3_n;
        any_wr = ~&byte_wr_n;
        cmd    = CMD_IDLE;
        is_wr  = 1'b0;
        if (!chip_en_n && !proc_stb_n) begin
            // processor strobe wins, always a read
            cmd = sec_ok ? CMD_LOAD : CMD_DESEL;
        end else if (!ctrl_stb_n) begin
            if (!chip_en_n && sec_ok) begin
                cmd   = CMD_LOAD;
                is_wr = any_wr;
            end else begin
                cmd = CMD_DESEL;
            end
        end else if (burst_active) begin
            cmd   = CMD_CONT;
            is_wr = any_wr;
        end
    end

endmodule

// File: rtl/sb_burst_seq.sv
module sb_burst_seq
    import sburst_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic              cmd_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              step_n,
    input  logic              order_il,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              acc_en,
    output logic              acc_wr,
    output logic              active
);

    localparam int HI_W = ADDR_W - 2;

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        beat_addr = seq_q.base;
        acc_en    = 1'b0;
        acc_wr    = 1'b0;
        case (cmd)
            CMD_LOAD: begin
                seq_d.active = 1'b1;
                seq_d.base   = addr;
                seq_d.cnt    = 2'd0;
                beat_addr    = addr;
                acc_en       = 1'b1;
                acc_wr       = cmd_wr;
            end
            CMD_DESEL: begin
                seq_d.active = 1'b0;
            end
            CMD_CONT: begin
                seq_d.cnt = step_n ? seq_q.cnt : seq_q.cnt + 2'd1;
                beat_addr = {seq_q.base[ADDR_W-1 -: HI_W],
                             beat_offset(seq_q.base[1:0], seq_d.cnt, order_il)};
                acc_en    = 1'b1;
                acc_wr    = cmd_wr;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign active = seq_q.active;

    // R1 / R4: a load starts a burst at beat 0 from the sampled address
    assert_strobe_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOAD) |=> (seq_q.active && seq_q.cnt == 2'd0 && seq_q.base == $past(addr)));

    // R3: deselect ends the burst
    assert_desel_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_DESEL) |=> !seq_q.active);

    // R7: a hold keeps the beat position and base
    assert_hold_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_CONT && step_n) |=> ($stable(seq_q.cnt) && $stable(seq_q.base) && seq_q.active));

    // R7: a step advances exactly one beat
    assert_step_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_CONT && !step_n) |=> (seq_q.cnt == $past(seq_q.cnt) + 2'd1));

endmodule

// File: rtl/sb_lane_array.sv
module sb_lane_array #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [NBYTES-1:0]        byte_wr_n,
    input  logic [NBYTES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [NBYTES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we && !byte_wr_n[g]) mem_q[wr_addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem_q[rd_addr];
    end

endmodule

// File: rtl/sb_read_pipe.sv
module sb_read_pipe #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr_in,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    typedef struct packed {
        logic              s1_v;
        logic [ADDR_W-1:0] s1_a;
        logic              s2_v;
        logic [DATA_W-1:0] s2_d;
        logic              o_v;
        logic [DATA_W-1:0] o_d;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d      = pipe_q;
        pipe_d.s1_v = rd_req;
        if (rd_req) pipe_d.s1_a = rd_addr_in;
        pipe_d.s2_v = pipe_q.s1_v;
        if (pipe_q.s1_v) pipe_d.s2_d = arr_data;
        pipe_d.o_v  = pipe_q.s2_v;
        if (pipe_q.s2_v) pipe_d.o_d = pipe_q.s2_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign arr_addr = pipe_q.s1_a;
    assign rdata    = pipe_q.o_d;
    assign rvalid   = pipe_q.o_v;

    // R8: a returned beat traces back to a read request three samples earlier
    assert_rvalid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(rd_req, 3));

    // R8: output data holds while no beat is returned
    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_q.s2_v |=> $stable(rdata));

endmodule

// File: rtl/sburst_sram_core.sv
module sburst_sram_core
    import sburst_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     chip_en_n,
    input  logic                     chip_en2,
    input  logic                     chip_en3_n,
    input  logic                     proc_stb_n,
    input  logic                     ctrl_stb_n,
    input  logic                     step_n,
    input  logic [NBYTES-1:0]        byte_wr_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES*LANE_W-1:0] wdata,
    input  logic                     order_il,
    output logic [NBYTES*LANE_W-1:0] rdata,
    output logic                     rvalid
);

    localparam int DATA_W = NBYTES * LANE_W;

    cmd_e              cmd;
    logic              cmd_wr;
    logic              burst_active;
    logic [ADDR_W-1:0] beat_addr;
    logic              acc_en;
    logic              acc_wr;
    logic [ADDR_W-1:0] arr_addr;
    logic [DATA_W-1:0] arr_data;

    sb_strobe_decode #(.NBYTES(NBYTES)) u_decode (
        .chip_en_n    (chip_en_n),
        .chip_en2     (chip_en2),
        .chip_en3_n   (chip_en3_n),
        .proc_stb_n   (proc_stb_n),
        .ctrl_stb_n   (ctrl_stb_n),
        .byte_wr_n    (byte_wr_n),
        .burst_active (burst_active),
        .cmd          (cmd),
        .is_wr        (cmd_wr)
    );

    sb_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .cmd_wr    (cmd_wr),
        .addr      (addr),
        .step_n    (step_n),
        .order_il  (order_il),
        .beat_addr (beat_addr),
        .acc_en    (acc_en),
        .acc_wr    (acc_wr),
        .active    (burst_active)
    );

    sb_lane_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .LANE_W(LANE_W)) u_array (
        .clk       (clk),
        .we        (acc_en && acc_wr),
        .wr_addr   (beat_addr),
        .byte_wr_n (byte_wr_n),
        .wdata     (wdata),
        .rd_addr   (arr_addr),
        .rd_data   (arr_data)
    );

    sb_read_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (acc_en && !acc_wr),
        .rd_addr_in (beat_addr),
        .arr_addr   (arr_addr),
        .arr_data   (arr_data),
        .rdata      (rdata),
        .rvalid     (rvalid)
    );

    // R1: an honoured processor strobe never writes, even with the other strobe low
    assert_proc_read_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en_n && !proc_stb_n) |-> !(acc_en && acc_wr));

    // R2: with the primary enable high and no controller strobe, a burst survives
    assert_proc_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en_n && ctrl_stb_n && burst_active) |=> burst_active);

    // R5: controller strobe with primary enable high deselects
    assert_ctrl_desel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_stb_n && chip_en_n) |=> !burst_active);

    // R3: honoured processor strobe with a secondary enable off makes no access
    assert_proc_desel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en_n && !proc_stb_n && (!chip_en2 || chip_en3_n)) |-> !acc_en);

endmodule

// File: tb/sburst_sram_core_tb_top.sv
module sburst_sram_core_tb_top;

    localparam int AW    = 6;
    localparam int NB    = 2;
    localparam int LW    = 9;
    localparam int DW    = NB * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          chip_en_n, chip_en2, chip_en3_n;
    logic          proc_stb_n, ctrl_stb_n, step_n;
    logic [NB-1:0] byte_wr_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          order_il;
    logic [DW-1:0] rdata;
    logic          rvalid;

    always #5 clk = ~clk;

    sburst_sram_core #(.ADDR_W(AW), .NBYTES(NB), .LANE_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .chip_en2(chip_en2),
        .chip_en3_n(chip_en3_n), .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
        .step_n(step_n), .byte_wr_n(byte_wr_n), .addr(addr), .wdata(wdata),
        .order_il(order_il), .rdata(rdata), .rvalid(rvalid)
    );

    // reference model state
    logic [DW-1:0] mmem [DEPTH];
    logic          m_active;
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    logic          m_s1_v, m_s2_v, m_out_v;
    logic [AW-1:0] m_s1_a;
    logic [DW-1:0] m_s2_d, m_out_d;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    string cur_req = "R10";

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_off(input logic [1:0] s, input logic [1:0] k,
                                           input logic il);
        // R6: linear (s+k) mod 4, interleaved s xor k
        return il ? (s ^ k) : ((s + k) & 2'd3);
    endfunction

    task automatic model_edge();
        logic          sec, anyw, acc, wr;
        logic [AW-1:0] ba;
        m_out_v = m_s2_v;
        if (m_s2_v) m_out_d = m_s2_d;
        m_s2_v = m_s1_v;
        m_s2_d = mmem[m_s1_a];
        m_s1_v = 1'b0;
        sec  = chip_en2 && !chip_en3_n;
        anyw = (byte_wr_n != '1);
        acc  = 1'b0;
        wr   = 1'b0;
        ba   = addr;
        if (!chip_en_n && !proc_stb_n) begin
            if (sec) begin
                m_active = 1'b1; m_base = addr; m_cnt = 2'd0; acc = 1'b1;
            end else m_active = 1'b0;
        end else if (!ctrl_stb_n) begin
            if (!chip_en_n && sec) begin
                m_active = 1'b1; m_base = addr; m_cnt = 2'd0; acc = 1'b1; wr = anyw;
            end else m_active = 1'b0;
        end else if (m_active) begin
            if (!step_n) m_cnt = m_cnt + 2'd1;
            ba  = {m_base[AW-1:2], exp_off(m_base[1:0], m_cnt, order_il)};
            acc = 1'b1;
            wr  = anyw;
        end
        if (acc && wr) begin
            for (int i = 0; i < NB; i++)
                if (!byte_wr_n[i]) mmem[ba][i*LW +: LW] = wdata[i*LW +: LW];
        end
        if (acc && !wr) begin
            m_s1_v = 1'b1;
            m_s1_a = ba;
        end
    endtask

    // one clock: inputs already set at the falling edge
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(cur_req, "rvalid", {31'd0, rvalid}, {31'd0, m_out_v});
        if (m_out_v) check(cur_req, "rdata", {14'd0, rdata}, {14'd0, m_out_d});
    endtask

    task automatic set_in(input logic ps, input logic cs, input logic ce,
                          input logic c2, input logic c3, input logic st,
                          input logic [NB-1:0] bw, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd);
        proc_stb_n = ps; ctrl_stb_n = cs; chip_en_n = ce;
        chip_en2 = c2; chip_en3_n = c3; step_n = st;
        byte_wr_n = bw; addr = a; wdata = wd;
    endtask

    task automatic idle_hold(input int n);
        for (int i = 0; i < n; i++) begin
            set_in(1, 1, 0, 1, 0, 1, '1, '0, '0);
            tick();
        end
    endtask

    task automatic deselect();
        set_in(1, 0, 1, 1, 0, 1, '1, '0, '0);
        tick();
        idle_hold(3);
    endtask

    task automatic step_read(input int n);
        for (int i = 0; i < n; i++) begin
            set_in(1, 1, 0, 1, 0, 0, '1, '0, '0);
            tick();
        end
    endtask

    function automatic logic [DW-1:0] pattern(input int a);
        return DW'((a * 32'h9e37) ^ 32'h2a5c5);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        for (int i = 0; i < DEPTH; i++) mmem[i] = '0;
        m_active = 0; m_base = '0; m_cnt = '0;
        m_s1_v = 0; m_s2_v = 0; m_out_v = 0;
        m_s1_a = '0; m_s2_d = '0; m_out_d = '0;
        order_il = 1'b0;
        rst_n = 1'b0;
        set_in(1, 1, 1, 1, 0, 1, '1, '0, '0);
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "rvalid in reset", {31'd0, rvalid}, 32'd0);
        check("R10", "rdata in reset", {14'd0, rdata}, 32'd0);
        rst_n = 1'b1;
        cur_req = "R10";
        idle_hold(2);
        check("R10", "rvalid after reset", {31'd0, rvalid}, 32'd0);
        check("R10", "rdata after reset", {14'd0, rdata}, 32'd0);

        // R4: fill the array with controller-strobe writes
        cur_req = "R4";
        for (int a = 0; a < DEPTH; a++) begin
            set_in(1, 0, 0, 1, 0, 1, '0, AW'(a), pattern(a));
            tick();
        end
        // R4: controller-strobe read
        set_in(1, 0, 0, 1, 0, 1, '1, 6'd17, '0);
        tick();
        idle_hold(3);

        // R5: controller strobe with primary enable high deselects
        cur_req = "R5";
        deselect();
        set_in(1, 0, 0, 0, 0, 1, '1, 6'd9, '0); // secondary enable off
        tick();
        idle_hold(3);

        // R1: processor strobe beats controller strobe and byte enables
        cur_req = "R1";
        set_in(0, 0, 0, 1, 0, 1, '0, 6'd5, 18'h3ffff);
        tick();
        step_read(3);
        idle_hold(2);
        set_in(0, 1, 0, 1, 0, 1, '1, 6'd5, '0);
        tick();
        idle_hold(3);
        check("R1", "word 5 unchanged", {14'd0, rdata}, {14'd0, pattern(5)});

        // R2: processor strobe with primary enable high has no effect
        cur_req = "R2";
        set_in(0, 1, 0, 1, 0, 1, '1, 6'd8, '0);
        tick();
        set_in(0, 1, 1, 1, 0, 0, '1, 6'd40, '0);
        tick();
        set_in(0, 1, 1, 1, 0, 1, '1, 6'd40, '0);
        tick();
        idle_hold(3);
        check("R2", "burst beat 9 returned", {14'd0, rdata}, {14'd0, pattern(9)});

        // R3: honoured processor strobe with secondary enables off
        cur_req = "R3";
        set_in(0, 1, 0, 0, 0, 1, '1, 6'd11, '0);
        tick();
        idle_hold(4);
        check("R3", "no beat after deselect", {31'd0, rvalid}, 32'd0);
        set_in(0, 1, 0, 1, 1, 1, '1, 6'd12, '0);
        tick();
        step_read(4);
        check("R3", "no beat after deselect 2", {31'd0, rvalid}, 32'd0);

        // R6: linear then interleaved from offset 1
        cur_req = "R6";
        set_in(0, 1, 0, 1, 0, 1, '1, 6'd13, '0);
        tick();
        step_read(3);
        idle_hold(2);
        deselect();
        order_il = 1'b1;
        set_in(0, 1, 0, 1, 0, 1, '1, 6'd13, '0);
        tick();
        step_read(3);
        idle_hold(2);
        // wrap past four beats in interleaved order
        step_read(3);
        deselect();
        order_il = 1'b0;

        // R7: write burst with steps and a hold, then read back
        cur_req = "R7";
        set_in(1, 0, 0, 1, 0, 1, '0, 6'd22, 18'h12345);
        tick();
        set_in(1, 1, 0, 1, 0, 0, '0, '0, 18'h2aaaa);
        tick();
        set_in(1, 1, 0, 1, 0, 1, '0, '0, 18'h15555);
        tick();
        set_in(1, 1, 0, 1, 0, 0, '0, '0, 18'h0f0f0);
        tick();
        set_in(0, 1, 0, 1, 0, 1, '1, 6'd22, '0);
        tick();
        step_read(3);
        idle_hold(3);

        // R9: single-lane write keeps the other lane, parity bits included
        cur_req = "R9";
        set_in(1, 0, 0, 1, 0, 1, 2'b10, 6'd30, 18'h3ff00);
        tick();
        set_in(1, 0, 0, 1, 0, 1, 2'b01, 6'd31, 18'h201ff);
        tick();
        set_in(0, 1, 0, 1, 0, 1, '1, 6'd30, '0);
        tick();
        idle_hold(2);
        check("R9", "lane0 replaced lane1 kept", {14'd0, rdata},
              {14'd0, pattern(30)[17:9], 9'h100});
        deselect();

        // R8: constrained random under each burst order
        cur_req = "R8";
        for (int pass = 0; pass < 2; pass++) begin
            order_il = pass[0];
            for (int i = 0; i < 1500; i++) begin
                logic [NB-1:0] bw;
                bw = ($urandom % 2 == 0) ? '1 : NB'($urandom);
                set_in(($urandom % 100) >= 15, ($urandom % 100) >= 20,
                       ($urandom % 100) >= 85, ($urandom % 100) < 90,
                       ($urandom % 100) >= 90, 1'($urandom),
                       bw, AW'($urandom), DW'($urandom));
                tick();
            end
            deselect();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule